// File: doc/BRIEF.md
# Standby-Aware Two-Channel Conversion Sequencer

This block decides when a temperature converter may run, and on which channel. It drives a one-cycle start pulse and a channel select toward a converter, waits for a done strobe, and stores each returned code in the value register for that channel. Channel 0 is the on-die sensor and channel 1 is the external diode. When the block is awake it converts channel 0, then channel 1, and repeats without a gap. Two sleep sources stop this loop. One is an active-low pin. The other is a bit in a configuration register. Either source cancels a conversion in flight, and the code from that conversion is thrown away.

The two sleep sources do not act the same way. Under software sleep with the pin high, a write to the single-pass trigger address starts exactly one local-plus-remote pass. After that pass the block returns to idle. Under pin sleep every start is blocked. The register side is a simple write strobe with an address and data, driven by a bus front end outside this block. Nothing in this block stops that path in either sleep state.

At the start of each pass the block samples an open-sensor comparator. It also flags the remote code that means "below range". It compares both stored readings against signed high and low limits, and it drives an active-low alert from the result.

Top module: `tconv_sequencer`

## Requirements
- R1: While reset is applied, `adc_start` and `busy` are 0. Both stored temperatures read 0x00, every limit flag is 0, `open_flag` is 0 and `alert_n` is 1.
- R2: With `hw_sleep_n` high and configuration bit 6 at 0, the block runs continuously. One cycle after leaving idle, `adc_start` pulses with `adc_sel`=0. In the cycle after an accepted `adc_done`, the code has been stored and the next start pulse is out. The next start selects the other channel. After channel 1 the next start selects channel 0.
- R3: A write to address 0x09 stores bit 6 of the data as the software sleep bit. Setting it during a continuous conversion returns the block to idle before the next conversion, and the stored value of that channel does not change.
- R4: While `hw_sleep_n` is low, no conversion starts and a write to 0x0F has no effect. Pulling the pin low during a conversion aborts it, and the stored value does not change.
- R5: With software sleep set and `hw_sleep_n` high, any write to address 0x0F runs one conversion of channel 0 and then one of channel 1. Both results are stored and the block returns to idle.
- R6: A write to 0x0F that arrives while a single pass is running is ignored. The pass still issues exactly two starts.
- R7: `open_flag` takes the value of `sensor_open` in the cycle where `adc_start` is high with `adc_sel`=0. At all other times it holds its value.
- R8: `remote_short` is 1 exactly when the stored remote code is 0x80.
- R9: Limits are written at 0x0B (local high), 0x0C (local low), 0x0D (remote high) and 0x0E (remote low). A flag is set when the reading is strictly above its high limit or strictly below its low limit, comparing in two's complement. The flag bits are: bit 0 local above, bit 1 local below, bit 2 remote above, bit 3 remote below.
- R10: `alert_n` is 0 when any limit flag or `open_flag` is 1. With a remote low limit of 0x80, a remote code of 0x80 raises no alert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_sleep_n | input | 1 | Pin sleep request, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | DW | Register write data |
| sensor_open | input | 1 | Open-sensor comparator output |
| adc_done | input | 1 | Converter result valid strobe |
| adc_data | input | DW | Converter result code |
| adc_start | output | 1 | One-cycle conversion start |
| adc_sel | output | 1 | Channel select: 0 local, 1 remote |
| busy | output | 1 | A conversion is in progress |
| sleeping | output | 1 | Either sleep source is active |
| local_temp | output | DW | Stored local reading |
| remote_temp | output | DW | Stored remote reading |
| open_flag | output | 1 | Sampled open-sensor status |
| remote_short | output | 1 | Remote reading equals the below-range code |
| limit_flags | output | 4 | Out-of-limit flags |
| alert_n | output | 1 | Active-low alert |

## Verification
The bench sets software sleep while a remote conversion is running, and later pulls the pin low during a local conversion. A design that did not discard aborted results would then show the code the converter delivers later, rather than the old value. The bench sends a second single-pass trigger in the middle of a pass, and one under pin sleep. A design that ignored the sleep distinction, or queued the extra request, would issue four starts or two instead of two or zero. Codes at exactly the limits, negative local codes and the 0x80 remote code test the comparison. An unsigned compare, or a compare that is not strict, would flip bits 1 and 3 or raise flags at equality. The bench also raises the comparator while idle. A flag that updated outside a pass start would then show an open sensor too early.

// File: rtl/tconv_pkg.sv
package tconv_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOC  = 2'd1,
      ST_REM  = 2'd2
   } conv_st_e;

   localparam int unsigned NUM_CH    = 2;
   localparam int unsigned CH_LOCAL  = 0;
   localparam int unsigned CH_REMOTE = 1;
endpackage

// File: rtl/tconv_regs.sv
module tconv_regs
   import tconv_pkg::*;
#(
   parameter int unsigned    DW        = 8,
   parameter int unsigned    AW        = 8,
   parameter logic [AW-1:0]  CFG_ADDR  = 8'h09,
   parameter logic [AW-1:0]  OS_ADDR   = 8'h0F,
   parameter logic [AW-1:0]  LIM_BASE  = 8'h0B,
   parameter int unsigned    SLEEP_BIT = 6
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [AW-1:0]                 wr_addr,
   input  logic [DW-1:0]                 wr_data,
   output logic                          sw_sleep,
   output logic                          oneshot_wr,
   output logic [NUM_CH-1:0][DW-1:0]     lim_hi,
   output logic [NUM_CH-1:0][DW-1:0]     lim_lo
);
   localparam logic [DW-1:0] HI_RST = {1'b0, {(DW-1){1'b1}}};
   localparam logic [DW-1:0] LO_RST = {1'b1, {(DW-1){1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             sw_sleep <= 1'b0;
      else if (wr_en && wr_addr == CFG_ADDR)  sw_sleep <= wr_data[SLEEP_BIT];
   end

   assign oneshot_wr = wr_en && (wr_addr == OS_ADDR);

   for (genvar g = 0; g < NUM_CH; g++) begin : g_lim
      localparam logic [AW-1:0] HI_A = LIM_BASE + AW'(2 * g);
      localparam logic [AW-1:0] LO_A = LIM_BASE + AW'(2 * g + 1);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lim_hi[g] <= HI_RST;
            lim_lo[g] <= LO_RST;
         end else if (wr_en) begin
            if (wr_addr == HI_A) lim_hi[g] <= wr_data;
            if (wr_addr == LO_A) lim_lo[g] <= wr_data;
         end
      end
   end

   p_cfg_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == CFG_ADDR) |=> (sw_sleep == $past(wr_data[SLEEP_BIT])));
   p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == CFG_ADDR) |=> $stable(sw_sleep));
endmodule

// File: rtl/tconv_ctrl.sv
module tconv_ctrl
   import tconv_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic hw_sleep_n,
   input  logic sw_sleep,
   input  logic oneshot_wr,
   input  logic adc_done,
   output logic adc_start,
   output logic adc_sel,
   output logic res_we,
   output logic res_ch,
   output logic busy,
   output logic sleeping
);
   conv_st_e st_q, st_n;
   logic     os_q, os_n, start_n, abort;

   assign sleeping = !hw_sleep_n || sw_sleep;
   assign busy     = (st_q != ST_IDLE);
   assign adc_sel  = (st_q == ST_REM);
   // a single pass survives software sleep; only the pin stops it
   assign abort    = busy && (os_q ? !hw_sleep_n : sleeping);

   always_comb begin
      st_n    = st_q;
      os_n    = os_q;
      start_n = 1'b0;
      res_we  = 1'b0;
      res_ch  = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (!sleeping) begin
               st_n = ST_LOC; os_n = 1'b0; start_n = 1'b1;
            end else if (oneshot_wr && hw_sleep_n) begin
               st_n = ST_LOC; os_n = 1'b1; start_n = 1'b1;
            end
         end
         ST_LOC: begin
            if (abort) begin
               st_n = ST_IDLE; os_n = 1'b0;
            end else if (adc_done) begin
               res_we = 1'b1; res_ch = 1'b0;
               st_n = ST_REM; start_n = 1'b1;
            end
         end
         ST_REM: begin
            if (abort) begin
               st_n = ST_IDLE; os_n = 1'b0;
            end else if (adc_done) begin
               res_we = 1'b1; res_ch = 1'b1;
               if (os_q) begin
                  st_n = ST_IDLE; os_n = 1'b0;
               end else begin
                  st_n = ST_LOC; start_n = 1'b1;
               end
            end
         end
         default: begin
            st_n = ST_IDLE; os_n = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         os_q      <= 1'b0;
         adc_start <= 1'b0;
      end else begin
         st_q      <= st_n;
         os_q      <= os_n;
         adc_start <= start_n;
      end
   end

   p_pin_inhibit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !hw_sleep_n |=> !adc_start);
   p_abort_no_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !os_q && sleeping) |-> !res_we);
   p_abort_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !os_q && sleeping) |=> !busy);
   p_pass_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (os_q && res_we && res_ch) |=> (!busy && !adc_start));
   p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_start && !adc_done) |=> !adc_start);
   p_no_retrigger_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (os_q && busy && !res_we && hw_sleep_n) |=> (busy && !adc_start));
endmodule

// File: rtl/tconv_results.sv
module tconv_results
   import tconv_pkg::*;
#(
   parameter int unsigned DW        = 8,
   parameter bit          REG_FLAGS = 1'b0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          res_we,
   input  logic                          res_ch,
   input  logic [DW-1:0]                 adc_data,
   input  logic                          adc_start,
   input  logic                          adc_sel,
   input  logic                          sensor_open,
   input  logic [NUM_CH-1:0][DW-1:0]     lim_hi,
   input  logic [NUM_CH-1:0][DW-1:0]     lim_lo,
   output logic [NUM_CH-1:0][DW-1:0]     vals,
   output logic                          open_flag,
   output logic                          remote_short,
   output logic [2*NUM_CH-1:0]           limit_flags,
   output logic                          alert_n
);
   localparam logic [DW-1:0] FAULT_CODE = {1'b1, {(DW-1){1'b0}}};

   logic [2*NUM_CH-1:0] cmp_raw;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         vals[g] <= '0;
         else if (res_we && res_ch == 1'(g)) vals[g] <= adc_data;
      end
      assign cmp_raw[2*g]     = $signed(vals[g]) > $signed(lim_hi[g]);
      assign cmp_raw[2*g + 1] = $signed(vals[g]) < $signed(lim_lo[g]);

      p_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (res_we && res_ch == 1'(g)) |=> (vals[g] == $past(adc_data)));
      p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
         !(res_we && res_ch == 1'(g)) |=> $stable(vals[g]));
   end

   if (REG_FLAGS) begin : g_flag_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) limit_flags <= '0;
         else        limit_flags <= cmp_raw;
      end
   end else begin : g_flag_comb
      assign limit_flags = cmp_raw;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      open_flag <= 1'b0;
      else if (adc_start && !adc_sel)  open_flag <= sensor_open;
   end

   assign remote_short = (vals[CH_REMOTE] == FAULT_CODE);
   assign alert_n      = !((|limit_flags) || open_flag);

   p_open_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_start && !adc_sel) |=> (open_flag == $past(sensor_open)));
   p_open_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(adc_start && !adc_sel) |=> $stable(open_flag));
   p_open_alert_r10: assert property (@(posedge clk) disable iff (!rst_n)
      open_flag |-> !alert_n);
endmodule

// File: rtl/tconv_sequencer.sv
module tconv_sequencer
   import tconv_pkg::*;
#(
   parameter int unsigned    DW        = 8,
   parameter int unsigned    AW        = 8,
   parameter logic [AW-1:0]  CFG_ADDR  = 8'h09,
   parameter logic [AW-1:0]  OS_ADDR   = 8'h0F,
   parameter logic [AW-1:0]  LIM_BASE  = 8'h0B,
   parameter int unsigned    SLEEP_BIT = 6,
   parameter bit             REG_FLAGS = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hw_sleep_n,
   input  logic            wr_en,
   input  logic [AW-1:0]   wr_addr,
   input  logic [DW-1:0]   wr_data,
   input  logic            sensor_open,
   input  logic            adc_done,
   input  logic [DW-1:0]   adc_data,
   output logic            adc_start,
   output logic            adc_sel,
   output logic            busy,
   output logic            sleeping,
   output logic [DW-1:0]   local_temp,
   output logic [DW-1:0]   remote_temp,
   output logic            open_flag,
   output logic            remote_short,
   output logic [3:0]      limit_flags,
   output logic            alert_n
);
   localparam int unsigned LIM_REGS = 2 * NUM_CH;

   initial begin
      a_dw_min: assert (DW >= 2) else $error("DW too small");
      a_sleep_bit: assert (SLEEP_BIT < DW) else $error("SLEEP_BIT outside data word");
      a_addr_clash: assert (OS_ADDR != CFG_ADDR) else $error("trigger and config share an address");
      a_lim_clash: assert (!(int'(CFG_ADDR) >= int'(LIM_BASE) && int'(CFG_ADDR) < int'(LIM_BASE) + LIM_REGS))
         else $error("config address inside limit window");
      a_lim_os: assert (!(int'(OS_ADDR) >= int'(LIM_BASE) && int'(OS_ADDR) < int'(LIM_BASE) + LIM_REGS))
         else $error("trigger address inside limit window");
   end

   logic                       sw_sleep, oneshot_wr, res_we, res_ch;
   logic [NUM_CH-1:0][DW-1:0]  lim_hi, lim_lo, vals;

   tconv_regs #(
      .DW(DW), .AW(AW), .CFG_ADDR(CFG_ADDR), .OS_ADDR(OS_ADDR),
      .LIM_BASE(LIM_BASE), .SLEEP_BIT(SLEEP_BIT)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .sw_sleep(sw_sleep), .oneshot_wr(oneshot_wr), .lim_hi(lim_hi), .lim_lo(lim_lo)
   );

   tconv_ctrl i_ctrl (
      .clk(clk), .rst_n(rst_n), .hw_sleep_n(hw_sleep_n), .sw_sleep(sw_sleep),
      .oneshot_wr(oneshot_wr), .adc_done(adc_done), .adc_start(adc_start),
      .adc_sel(adc_sel), .res_we(res_we), .res_ch(res_ch), .busy(busy),
      .sleeping(sleeping)
   );

   tconv_results #(.DW(DW), .REG_FLAGS(REG_FLAGS)) i_results (
      .clk(clk), .rst_n(rst_n), .res_we(res_we), .res_ch(res_ch), .adc_data(adc_data),
      .adc_start(adc_start), .adc_sel(adc_sel), .sensor_open(sensor_open),
      .lim_hi(lim_hi), .lim_lo(lim_lo), .vals(vals), .open_flag(open_flag),
      .remote_short(remote_short), .limit_flags(limit_flags), .alert_n(alert_n)
   );

   assign local_temp  = vals[CH_LOCAL];
   assign remote_temp = vals[CH_REMOTE];
endmodule

// File: tb/test_tconv_sequencer.sv
module test_tconv_sequencer;
   localparam int  CLK_PERIOD = 10;
   localparam int  LAT        = 4;
   localparam logic [7:0] A_CFG = 8'h09, A_OS = 8'h0F;
   localparam logic [7:0] A_LH = 8'h0B, A_LL = 8'h0C, A_RH = 8'h0D, A_RL = 8'h0E;
   // {local code, remote code, open, flags[3:0], short, alert_n}
   localparam int NV = 8;
   localparam logic [22:0] VECS [NV] = '{
      {8'h20, 8'h30, 1'b0, 4'b0000, 1'b0, 1'b1},
      {8'h51, 8'h30, 1'b0, 4'b0001, 1'b0, 1'b0},
      {8'h50, 8'h60, 1'b0, 4'b0000, 1'b0, 1'b1},
      {8'h04, 8'h61, 1'b0, 4'b0110, 1'b0, 1'b0},
      {8'hF0, 8'h10, 1'b0, 4'b0010, 1'b0, 1'b0},
      {8'h20, 8'h80, 1'b0, 4'b1000, 1'b1, 1'b0},
      {8'h20, 8'h30, 1'b1, 4'b0000, 1'b0, 1'b0},
      {8'h05, 8'h00, 1'b0, 4'b0000, 1'b0, 1'b1}
   };

   logic clk = 1'b0, rst_n = 1'b0, hw_sleep_n = 1'b0, wr_en = 1'b0;
   logic [7:0] wr_addr = '0, wr_data = '0, adc_data = '0;
   logic sensor_open = 1'b0, adc_done = 1'b0;
   logic adc_start, adc_sel, busy, sleeping, open_flag, remote_short, alert_n;
   logic [7:0] local_temp, remote_temp;
   logic [3:0] limit_flags;

   logic [7:0] loc_code = 8'h00, rem_code = 8'h00;
   int cnt = 0, n_starts = 0, checks = 0, errors = 0;
   logic [1:0] sel_hist = '0;

   tconv_sequencer i_tconv_sequencer (
      .clk(clk), .rst_n(rst_n), .hw_sleep_n(hw_sleep_n), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .sensor_open(sensor_open),
      .adc_done(adc_done), .adc_data(adc_data), .adc_start(adc_start),
      .adc_sel(adc_sel), .busy(busy), .sleeping(sleeping), .local_temp(local_temp),
      .remote_temp(remote_temp), .open_flag(open_flag), .remote_short(remote_short),
      .limit_flags(limit_flags), .alert_n(alert_n)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural converter and start monitor
   always @(negedge clk) begin
      if (adc_done) adc_done = 1'b0;
      if (!rst_n) cnt = 0;
      else if (adc_start) begin
         cnt = LAT;
         n_starts = n_starts + 1;
         sel_hist = {sel_hist[0], adc_sel};
      end else if (cnt > 0) begin
         cnt = cnt - 1;
         if (cnt == 0) begin
            adc_done = 1'b1;
            adc_data = adc_sel ? rem_code : loc_code;
         end
      end
   end

   task automatic tick();
      @(negedge clk); #1;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wreg(input logic [7:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      tick();
      wr_en = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int n0;
      logic [7:0] prev;
      ticks(3);
      // R1 reset state
      chk("R1 adc_start", adc_start, 0);
      chk("R1 busy", busy, 0);
      chk("R1 temps", {local_temp, remote_temp}, 0);
      chk("R1 flags", {limit_flags, open_flag}, 0);
      chk("R1 alert_n", alert_n, 1);
      rst_n = 1'b1;
      tick();
      // R2 exact start and store timing
      loc_code = 8'h21; rem_code = 8'h32;
      hw_sleep_n = 1'b1;
      tick();
      chk("R2 first start", {adc_start, adc_sel, busy}, 3'b101);
      tick();
      chk("R2 start is a pulse", adc_start, 0);
      while (!adc_done) tick();
      tick();
      chk("R2 local stored", local_temp, 8'h21);
      chk("R2 remote start", {adc_start, adc_sel}, 2'b11);
      while (!adc_done) tick();
      tick();
      chk("R2 remote stored", remote_temp, 8'h32);
      chk("R2 back-to-back local start", {adc_start, adc_sel}, 2'b10);
      // R9 limits and vector table
      wreg(A_LH, 8'h50); wreg(A_LL, 8'h05); wreg(A_RH, 8'h60); wreg(A_RL, 8'h00);
      for (int v = 0; v < NV; v++) begin
         loc_code = VECS[v][22:15]; rem_code = VECS[v][14:7]; sensor_open = VECS[v][6];
         ticks(40);
         chk("R2 vec local", local_temp, VECS[v][22:15]);
         chk("R2 vec remote", remote_temp, VECS[v][14:7]);
         chk("R9 vec flags", limit_flags, VECS[v][5:2]);
         chk("R8 vec short", remote_short, VECS[v][1]);
         chk("R10 vec alert", alert_n, VECS[v][0]);
         chk("R7 vec open", open_flag, VECS[v][6]);
      end
      // R10 low limit of 0x80 masks the shorted remote channel
      rem_code = 8'h80; wreg(A_RL, 8'h80);
      ticks(40);
      chk("R8 short code", remote_short, 1);
      chk("R10 masked flags", limit_flags, 0);
      chk("R10 masked alert", alert_n, 1);
      // R3 software sleep aborts a remote conversion
      while (!(adc_start && adc_sel)) tick();
      prev = remote_temp; rem_code = 8'h44;
      wreg(A_CFG, 8'h40);
      n0 = n_starts;
      ticks(20);
      chk("R3 remote unchanged", remote_temp, prev);
      chk("R3 idle", {busy, sleeping}, 2'b01);
      chk("R3 no starts", n_starts - n0, 0);
      // R7 comparator not sampled while idle
      sensor_open = 1'b1;
      ticks(10);
      chk("R7 idle hold", open_flag, 0);
      chk("R10 idle alert", alert_n, 1);
      // R5 single pass under software sleep
      loc_code = 8'h11; rem_code = 8'h22; n0 = n_starts;
      wreg(A_OS, 8'hA5);
      ticks(30);
      chk("R5 two starts", n_starts - n0, 2);
      chk("R5 order", sel_hist, 2'b01);
      chk("R5 idle after", busy, 0);
      chk("R5 results", {local_temp, remote_temp}, 16'h1122);
      chk("R7 sampled at pass", open_flag, 1);
      // R6 retrigger during a pass
      sensor_open = 1'b0; n0 = n_starts;
      wreg(A_OS, 8'h00);
      ticks(3);
      chk("R6 running", busy, 1);
      wreg(A_OS, 8'h3C);
      ticks(30);
      chk("R6 still two starts", n_starts - n0, 2);
      chk("R6 idle", busy, 0);
      // R4 pin sleep blocks the trigger
      hw_sleep_n = 1'b0; n0 = n_starts;
      wreg(A_OS, 8'hFF);
      ticks(30);
      chk("R4 no starts", n_starts - n0, 0);
      chk("R4 sleeping", {sleeping, busy}, 2'b10);
      // R4 pin aborts a continuous local conversion
      hw_sleep_n = 1'b1;
      wreg(A_CFG, 8'h00);
      while (!(adc_start && !adc_sel)) tick();
      prev = local_temp; loc_code = 8'h33;
      hw_sleep_n = 1'b0;
      ticks(20);
      chk("R4 local unchanged", local_temp, prev);
      chk("R4 idle", busy, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule